// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer with a small register window. The clock is first divided by a programmable 8-bit prescaler and then by a fixed factor of 16, 32, 64 or 128. Each divided tick decrements a 16-bit down-counter. When the counter is ticked while already at zero, the watchdog has expired. The block then reloads the counter from a reload register, and it can raise a one-cycle interrupt pulse, a 128-cycle system reset pulse, or both, as the control bits select.

Software keeps the system alive by writing the counter register before it runs out, usually with the reload value. It can stop the countdown by clearing the run bit, and it can stop expiry from resetting the system by clearing the reset bit. There are three registers: control at address 0, reload at address 1 and live count at address 2. A read returns data one cycle after the address is presented.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset, control reads 0xFF1D (run on, reset-on-expiry on, interrupt off, divider code 3, prescaler 255), reload and count both read 0x8000, and both outputs are low.
- R2: reg_rdata, one cycle after reg_addr is presented, holds control (address 0), reload (address 1) or the live count (address 2). Address 3 reads 0, and writes to address 3 change no register.
- R3: Control bits [15:8] hold a prescaler value P. The clock is divided by P+1 ahead of the fixed divider.
- R4: Control bits [4:3] hold a code S that selects a fixed divide of 16, 32, 64 or 128 for S = 0, 1, 2, 3.
- R5: Each divided tick decrements the count. A tick that finds the count at zero is an expiry: the count reloads from the reload register, so with reload N the expiry period is (N+1)·(P+1)·2^(4+S) clocks.
- R6: When control bit 1 is set, each expiry gives exactly one cycle of wdt_irq high. When the bit is clear, wdt_irq stays low.
- R7: When control bit 2 is set, each expiry drives wdt_sys_rst high for 128 consecutive cycles. When the bit is clear, wdt_sys_rst stays low.
- R8: With control bit 0 (run) clear, the count, the prescaler phase and the divider phase all hold.
- R9: A write to the count register loads the written value and overrides any tick in the same cycle. Rewriting it often enough prevents every expiry.
- R10: A write to control restarts the prescaler and divider phases from zero. No tick happens in the cycle of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for reg_addr/reg_wdata |
| reg_addr | input | 2 | Register address (0 control, 1 reload, 2 count) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| wdt_irq | output | 1 | One-cycle expiry interrupt pulse |
| wdt_sys_rst | output | 1 | 128-cycle expiry reset pulse |

## Verification
The assertions assume that the inputs are synchronous to clk and defined whenever reset is low. They also rely on the shortest expiry interval, 16 clocks, being longer than one cycle, which is what keeps interrupt pulses from touching each other. The stimulus changes inputs only on the falling edge and raises the write strobe for exactly one cycle per access. During the reset-pulse checks it chooses prescaler values that make the expiry period longer than the 128-cycle reset pulse, so a pulse is never retriggered while it is being measured.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned REG_W    = 16;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELD = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_IRQEN  = 1;
  localparam int unsigned B_RSTEN  = 2;
  localparam int unsigned B_SEL    = 3;
  localparam int unsigned B_PRE    = 8;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] pre_max_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pcnt_q;

  assign tick_o = run_i && !restart_i && (pcnt_q == pre_max_i);

  always_ff @(posedge clk) begin
    if (rst || restart_i)
      pcnt_q <= '0;
    else if (run_i) begin
      if (pcnt_q == pre_max_i) pcnt_q <= '0;
      else                     pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R3: phase never passes the programmed limit
  assert_pre_bound_R3: assert property (@(posedge clk) disable iff (rst)
    pcnt_q <= pre_max_i);
  // R8: frozen when not running
  assert_pre_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !restart_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/wdog_divsel.sv
module wdog_divsel #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned LOG2_MIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned NSEL = 1 << SEL_W;
  localparam int unsigned DW   = LOG2_MIN + NSEL - 1;

  logic [DW-1:0] lim_tab [NSEL];
  logic [DW-1:0] dcnt_q;
  logic [DW-1:0] lim;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_tab[g] = DW'((64'd1 << (LOG2_MIN + g)) - 64'd1);
  end

  assign lim    = lim_tab[sel_i];
  assign tick_o = run_i && !restart_i && tick_i && (dcnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || restart_i)
      dcnt_q <= '0;
    else if (run_i && tick_i) begin
      if (dcnt_q == lim) dcnt_q <= '0;
      else               dcnt_q <= dcnt_q + 1'b1;
    end
  end

  // R4: divider phase stays below the selected factor
  assert_div_bound_R4: assert property (@(posedge clk) disable iff (rst)
    dcnt_q <= lim);
  // R10: control write clears the phase
  assert_div_restart_R10: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (dcnt_q == '0));
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= CNT_INIT;
    else if (load_i)   cnt_q <= load_val_i;
    else if (expire_o) cnt_q <= reload_i;
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end

  // R9: a write lands regardless of a concurrent tick
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R5: without tick or write the count holds
  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int unsigned RST_CYCLES = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int unsigned RW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

  logic [RW-1:0] rem_q;
  logic          pulse_q;

  assign pulse_o = pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      pulse_q <= 1'b0;
    end else if (fire_i) begin
      rem_q   <= RW'(RST_CYCLES - 1);
      pulse_q <= 1'b1;
    end else if (rem_q != '0) begin
      rem_q   <= rem_q - 1'b1;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  // R7: output stays high while cycles remain
  assert_pulse_span_R7: assert property (@(posedge clk) disable iff (rst)
    (rem_q != '0) |-> pulse_q);
  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (rst)
    fire_i |=> pulse_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned LOG2_MIN   = 4,
  parameter int unsigned RST_CYCLES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              wdt_irq,
  output logic              wdt_sys_rst
);
  localparam logic [CNT_W-1:0] RELD_INIT = CNT_W'(1) << (CNT_W - 1);

  logic             run_q, irqen_q, rsten_q;
  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] reld_q;
  logic [CNT_W-1:0] ctrl_view;
  logic [CNT_W-1:0] cnt_w;
  logic             wr_ctrl, wr_reld, wr_cnt;
  logic             pre_tick, div_tick, expire;
  logic             irq_q;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_reld = reg_wr && (reg_addr == A_RELD);
  assign wr_cnt  = reg_wr && (reg_addr == A_CNT);

  always_comb begin
    ctrl_view                        = '0;
    ctrl_view[B_RUN]                 = run_q;
    ctrl_view[B_IRQEN]               = irqen_q;
    ctrl_view[B_RSTEN]               = rsten_q;
    ctrl_view[B_SEL +: SEL_W]        = sel_q;
    ctrl_view[B_PRE +: PRE_W]        = pre_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b1;
      irqen_q <= 1'b0;
      rsten_q <= 1'b1;
      sel_q   <= '1;
      pre_q   <= '1;
    end else if (wr_ctrl) begin
      run_q   <= reg_wdata[B_RUN];
      irqen_q <= reg_wdata[B_IRQEN];
      rsten_q <= reg_wdata[B_RSTEN];
      sel_q   <= reg_wdata[B_SEL +: SEL_W];
      pre_q   <= reg_wdata[B_PRE +: PRE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          reld_q <= RELD_INIT;
    else if (wr_reld) reld_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= ctrl_view;
        A_RELD:  reg_rdata <= reld_q;
        A_CNT:   reg_rdata <= cnt_w;
        default: reg_rdata <= '0;
      endcase
    end
  end

  wdog_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run_i(run_q), .restart_i(wr_ctrl),
    .pre_max_i(pre_q), .tick_o(pre_tick)
  );

  wdog_divsel #(.SEL_W(SEL_W), .LOG2_MIN(LOG2_MIN)) u_div (
    .clk(clk), .rst(rst), .run_i(run_q), .restart_i(wr_ctrl),
    .tick_i(pre_tick), .sel_i(sel_q), .tick_o(div_tick)
  );

  wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(div_tick), .load_i(wr_cnt),
    .load_val_i(reg_wdata), .reload_i(reld_q), .cnt_o(cnt_w),
    .expire_o(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= expire && irqen_q;
  end
  assign wdt_irq = irq_q;

  wdog_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rstp (
    .clk(clk), .rst(rst), .fire_i(expire && rsten_q), .pulse_o(wdt_sys_rst)
  );

  // R5: an interrupt follows a cycle in which the count sat at zero
  assert_irq_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
    wdt_irq |-> ($past(cnt_w) == '0));
  // R6: pulse is gated by the enable and lasts one cycle
  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
    wdt_irq |-> $past(irqen_q));
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
    wdt_irq |=> !wdt_irq);
  // R7: reset pulse only starts when enabled
  assert_rst_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_sys_rst) |-> $past(rsten_q));
  // R8: stopped timer keeps its count unless written
  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_cnt) |=> $stable(cnt_w));
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        wdt_irq, wdt_sys_rst;

  int n_vec = 0, n_bad = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  wdog_timer u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdt_irq(wdt_irq), .wdt_sys_rst(wdt_sys_rst)
  );

  // behavioural reference, updated once per rising edge
  int m_run, m_ie, m_re, m_sel, m_pre, m_reld, m_cnt;
  int m_pc, m_dc, m_irq, m_rst, m_left, m_rd;

  function automatic int ctrl_word();
    return m_run | (m_ie << 1) | (m_re << 2) | (m_sel << 3) | (m_pre << 8);
  endfunction

  always @(posedge clk) begin
    bit wc, wl, wn, pt, dt, ex;
    if (rst) begin
      m_run = 1; m_ie = 0; m_re = 1; m_sel = 3; m_pre = 255;
      m_reld = 32768; m_cnt = 32768; m_pc = 0; m_dc = 0;
      m_irq = 0; m_rst = 0; m_left = 0; m_rd = 0;
    end else begin
      wc = reg_wr && reg_addr == 0;
      wl = reg_wr && reg_addr == 1;
      wn = reg_wr && reg_addr == 2;
      case (reg_addr)
        0: m_rd = ctrl_word();
        1: m_rd = m_reld;
        2: m_rd = m_cnt;
        default: m_rd = 0;
      endcase
      pt = m_run && !wc && m_pc == m_pre;
      dt = pt && m_dc == (16 << m_sel) - 1;
      ex = dt && !wn && m_cnt == 0;
      if (wc) begin m_pc = 0; m_dc = 0; end
      else if (m_run) begin
        m_pc = pt ? 0 : m_pc + 1;
        if (pt) m_dc = dt ? 0 : m_dc + 1;
      end
      if (wn) m_cnt = reg_wdata;
      else if (ex) m_cnt = m_reld;
      else if (dt) m_cnt = m_cnt - 1;
      m_irq = ex && m_ie;
      if (ex && m_re) begin m_rst = 1; m_left = 127; end
      else if (m_left != 0) m_left--;
      else m_rst = 0;
      if (wc) begin
        m_run = reg_wdata[0]; m_ie = reg_wdata[1]; m_re = reg_wdata[2];
        m_sel = reg_wdata[4:3]; m_pre = reg_wdata[15:8];
      end
      if (wl) m_reld = reg_wdata;
    end
    #5;
    n_vec++;
    if (int'(reg_rdata) != m_rd) begin
      n_bad++; $display("FAIL %s rdata act=%h exp=%h", phase, reg_rdata, m_rd);
    end
    if (int'(wdt_irq) != m_irq) begin
      n_bad++; $display("FAIL R6 irq act=%0d exp=%0d", wdt_irq, m_irq);
    end
    if (int'(wdt_sys_rst) != m_rst) begin
      n_bad++; $display("FAIL R7 sys_rst act=%0d exp=%0d", wdt_sys_rst, m_rst);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++; $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(v);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 2'(a);
    @(negedge clk);
    v = int'(reg_rdata);
    reg_addr = 2'd2;
  endtask

  task automatic irq_gap(output int gap);
    do @(negedge clk); while (!wdt_irq);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!wdt_irq);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++; $display("FAIL watchdog act=%0d exp=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    int v, g, hi, seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    phase = "R1";
    rd(0, v); chk("R1 ctrl", v, 16'hFF1D);
    rd(1, v); chk("R1 reload", v, 16'h8000);
    rd(2, v); chk("R1 count", v, 16'h8000);
    chk("R1 irq", int'(wdt_irq), 0);
    chk("R1 sys_rst", int'(wdt_sys_rst), 0);
    // R2: map, unused address
    phase = "R2";
    wr(1, 5);
    rd(1, v); chk("R2 reload", v, 5);
    wr(3, 16'hFFFF);
    rd(3, v); chk("R2 addr3", v, 0);
    rd(0, v); chk("R2 ctrl kept", v, 16'hFF1D);
    rd(1, v); chk("R2 reload kept", v, 5);
    // R4/R5/R6: run with interrupt, divider code 0, prescale 0
    phase = "R4";
    wr(0, 16'h0003); wr(2, 5);
    irq_gap(g); chk("R4 R5 period div16", g, 6 * 16);
    wr(0, 16'h0103);
    irq_gap(g); chk("R3 period pre1 div16", g, 6 * 2 * 16);
    wr(0, 16'h020B);
    irq_gap(g); chk("R4 period pre2 div32", g, 6 * 3 * 32);
    wr(0, 16'h0013);
    irq_gap(g); chk("R4 period div64", g, 6 * 64);
    wr(0, 16'h001B);
    irq_gap(g); chk("R4 period div128", g, 6 * 128);
    // R10: repeated control writes hold off ticks
    phase = "R10";
    wr(2, 0);
    for (int i = 0; i < 20; i++) wr(0, 16'h0003);
    rd(2, v); chk("R10 count frozen by ctrl writes", v, 0);
    // R7: reset pulse without interrupt, prescale 1 (period 192)
    phase = "R7";
    wr(0, 16'h0105); wr(2, 5);
    seen = 0;
    do begin @(negedge clk); if (wdt_irq) seen++; end while (!wdt_sys_rst);
    hi = 0;
    while (wdt_sys_rst) begin @(negedge clk); hi++; if (wdt_irq) seen++; end
    chk("R7 pulse length", hi, 128);
    chk("R6 no irq when disabled", seen, 0);
    // R8: stop
    phase = "R8";
    wr(0, 16'h0000); wr(2, 9);
    repeat (300) @(negedge clk);
    rd(2, v); chk("R8 count held", v, 9);
    chk("R7 no reset when disabled", int'(wdt_sys_rst), 0);
    // R9: keep-alive
    phase = "R9";
    wr(0, 16'h0007); wr(1, 5); wr(2, 5);
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      for (int j = 0; j < 50; j++) begin
        @(negedge clk); if (wdt_irq || wdt_sys_rst) seen++;
      end
      wr(2, 5);
    end
    chk("R9 no expiry with keep-alive", seen, 0);
    irq_gap(g); chk("R9 expiry resumes", g, 6 * 16);
    done = 1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule